// File: doc/BRIEF.md
# Channel Context Poll Scheduler

This block decides which channel context entry the transmit engine looks at next when it searches for frames waiting to go out. All ordinary channel entries have the same priority. The block walks them in table order and wraps back to entry 0 after the last configured entry. The count of configured entries is a run-time input. The engine may instead name the next entry through an index-pointer request. After such a jump, the walk carries on from the entry after the one that was named.

One link-management channel sits outside the ordinary entries. When the management enable is high, every ordinary poll is followed by one poll of the management channel, so the two kinds alternate. When the enable is low, the management channel is never chosen.

The block holds each selection until the engine reports that poll as done. It then shows the next selection in the following cycle. The block does not read or parse the table contents.

Top module: `poll_sched`

## Requirements
- R1: While `rst_n` is low, `sel_valid` is 0. In the first cycle after reset is released, `sel_valid` is 1, `sel_idx` is 0 and `sel_mgmt` is 0.
- R2: A selection stays unchanged until `poll_done` is high at a clock edge while `sel_valid` is 1. A `poll_done` seen while `sel_valid` is 0 has no effect.
- R3: Once a poll is done, the next selection appears in the following cycle. When that selection is ordinary and no jump is taken, its index is one more than the previous ordinary index.
- R4: The walk wraps to entry 0 after entry `count-1`. Here `count` is `num_entries`, with 0 read as 1 and values above 8192 read as 8192. If `count` is lowered below the next entry in the walk, the walk restarts at entry 0.
- R5: While `mgmt_en` is 0, `sel_mgmt` never becomes 1.
- R6: When a poll is done on an ordinary selection while `mgmt_en` is 1, the next selection is the management channel. During a management poll, `sel_mgmt` is 1 and `sel_idx` reads 0.
- R7: After a management poll is done, the next selection is ordinary. It continues the walk from where it stood before the management poll.
- R8: A jump is taken when `jump_valid` is high together with an accepted `poll_done`, the next selection is ordinary, and `jump_idx` is below `count`. The selection is then `jump_idx`, and the walk resumes at `jump_idx+1`.
- R9: A jump request has no effect if `jump_idx` is not below `count`, or if the next selection is a management poll. In both cases the walk goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| num_entries | input | 14 | Number of configured ordinary entries (1 to 8192) |
| mgmt_en | input | 1 | Inserts a management poll after each ordinary poll |
| jump_valid | input | 1 | Index-pointer request, sampled together with poll_done |
| jump_idx | input | 13 | Entry named by the index-pointer request |
| poll_done | input | 1 | The engine has finished the current poll |
| sel_valid | output | 1 | A selection is being presented |
| sel_idx | output | 13 | Selected ordinary entry (0 during a management poll) |
| sel_mgmt | output | 1 | The current selection is the management channel |

## Verification
The hardest situation to reach is one where several rules act on the same accepted poll. Examples are a jump request that arrives just when a management poll is due, and a lowered entry count that leaves the stored walk position beyond the table. The stimulus enables management polling and then issues a jump on the done that leads into a management poll, which checks that the request is dropped. It later shrinks `num_entries` to 2 while the walk stands at entry 4, and sets it to 0, which checks the restart and the clamp. A done that is held high across the release of reset checks that the first edge after reset ignores it.

// File: rtl/poll_sched_pkg.sv
package poll_sched_pkg;
  localparam int IDX_W = 13;
  localparam int CNT_W = IDX_W + 1;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t MAX_CNT = cnt_t'(1 << IDX_W);

  // Effective table size: 0 reads as 1, anything above the index range is clamped.
  function automatic cnt_t eff_count(input cnt_t n);
    if (n == '0)
      return cnt_t'(1);
    else if (n > MAX_CNT)
      return MAX_CNT;
    else
      return n;
  endfunction

  function automatic logic idx_fits(input idx_t idx, input cnt_t n);
    return {1'b0, idx} < n;
  endfunction

  // Position after an entry; may equal n, which the pointer treats as a wrap.
  function automatic cnt_t step_after(input idx_t idx);
    return {1'b0, idx} + cnt_t'(1);
  endfunction
endpackage

// File: rtl/ps_pick.sv
module ps_pick
  import poll_sched_pkg::*;
(
  input  logic cur_mgmt,
  input  logic mgmt_en,
  input  logic jump_valid,
  input  idx_t jump_idx,
  input  idx_t seq_idx,
  input  cnt_t count,
  output logic nxt_mgmt,
  output idx_t nxt_idx,
  output logic jump_taken
);
  always_comb begin
    nxt_mgmt   = mgmt_en && !cur_mgmt;
    jump_taken = !nxt_mgmt && jump_valid && idx_fits(jump_idx, count);
    if (nxt_mgmt)
      nxt_idx = '0;
    else if (jump_taken)
      nxt_idx = jump_idx;
    else
      nxt_idx = seq_idx;
  end
endmodule

// File: rtl/ps_seq_ptr.sv
module ps_seq_ptr
  import poll_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  idx_t chosen,
  input  cnt_t count,
  output idx_t seq_idx,
  output logic seq_wrap
);
  cnt_t ptr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= cnt_t'(1);
    else if (load)
      ptr <= step_after(chosen);
  end

  assign seq_wrap = (ptr >= count);
  assign seq_idx  = seq_wrap ? '0 : ptr[IDX_W-1:0];
endmodule

// File: rtl/ps_sel_reg.sv
module ps_sel_reg
  import poll_sched_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic nxt_mgmt,
  input  idx_t nxt_idx,
  output logic sel_valid,
  output idx_t sel_idx,
  output logic sel_mgmt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_idx   <= '0;
      sel_mgmt  <= 1'b0;
    end else begin
      sel_valid <= 1'b1;
      if (load) begin
        sel_idx  <= nxt_idx;
        sel_mgmt <= nxt_mgmt;
      end
    end
  end
endmodule

// File: rtl/poll_sched.sv
module poll_sched
  import poll_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] num_entries,
  input  logic             mgmt_en,
  input  logic             jump_valid,
  input  logic [IDX_W-1:0] jump_idx,
  input  logic             poll_done,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_idx,
  output logic             sel_mgmt
);
  cnt_t count;
  idx_t seq_idx;
  idx_t nxt_idx;
  logic nxt_mgmt;
  logic advance;
  logic load_ord;
  logic jump_taken;
  logic seq_wrap;

  assign count    = eff_count(num_entries);
  assign advance  = poll_done && sel_valid;
  assign load_ord = advance && !nxt_mgmt;

  ps_pick u_pick (
    .cur_mgmt   (sel_mgmt),
    .mgmt_en    (mgmt_en),
    .jump_valid (jump_valid),
    .jump_idx   (jump_idx),
    .seq_idx    (seq_idx),
    .count      (count),
    .nxt_mgmt   (nxt_mgmt),
    .nxt_idx    (nxt_idx),
    .jump_taken (jump_taken)
  );

  ps_seq_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ord),
    .chosen   (nxt_idx),
    .count    (count),
    .seq_idx  (seq_idx),
    .seq_wrap (seq_wrap)
  );

  ps_sel_reg u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (advance),
    .nxt_mgmt  (nxt_mgmt),
    .nxt_idx   (nxt_idx),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sel_mgmt  (sel_mgmt)
  );
endmodule

// File: rtl/poll_sched_chk.sv
module poll_sched_chk
  import poll_sched_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] num_entries,
  input logic             mgmt_en,
  input logic             jump_valid,
  input logic [IDX_W-1:0] jump_idx,
  input logic             poll_done,
  input logic             sel_valid,
  input logic [IDX_W-1:0] sel_idx,
  input logic             sel_mgmt,
  input logic             advance,
  input logic             jump_taken
);
  cnt_t eff;
  assign eff = eff_count(num_entries);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !poll_done) |=> ($stable(sel_idx) && $stable(sel_mgmt)));

  p_no_mgmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !mgmt_en) |=> !sel_mgmt);

  p_interleave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && mgmt_en && !sel_mgmt) |=> sel_mgmt);

  p_mgmt_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_mgmt |-> (sel_idx == '0));

  p_back_to_ord_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sel_mgmt) |=> !sel_mgmt);

  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !(mgmt_en && !sel_mgmt)) |=> ({1'b0, sel_idx} < $past(eff)));

  p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> (!sel_mgmt && sel_idx == $past(jump_idx)));
endmodule

bind poll_sched poll_sched_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .num_entries (num_entries),
  .mgmt_en     (mgmt_en),
  .jump_valid  (jump_valid),
  .jump_idx    (jump_idx),
  .poll_done   (poll_done),
  .sel_valid   (sel_valid),
  .sel_idx     (sel_idx),
  .sel_mgmt    (sel_mgmt),
  .advance     (advance),
  .jump_taken  (jump_taken)
);

// File: tb/sim_poll_sched.sv
`timescale 1ns/1ps
module sim_poll_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] num_entries;
  logic        mgmt_en;
  logic        jump_valid;
  logic [12:0] jump_idx;
  logic        poll_done;
  logic        sel_valid;
  logic [12:0] sel_idx;
  logic        sel_mgmt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int q_idx[$];
  bit q_mgmt[$];
  string q_req[$];

  // bench-side model state
  bit m_mgmt = 0;
  int m_next = 1;
  int last_idx = 0;
  bit last_mgmt = 0;
  logic pend = 1'b0;

  always #5 clk = ~clk;

  poll_sched u0 (
    .clk(clk), .rst_n(rst_n), .num_entries(num_entries), .mgmt_en(mgmt_en),
    .jump_valid(jump_valid), .jump_idx(jump_idx), .poll_done(poll_done),
    .sel_valid(sel_valid), .sel_idx(sel_idx), .sel_mgmt(sel_mgmt)
  );

  function automatic int size_of(input int n);
    if (n == 0) return 1;
    if (n > 8192) return 8192;
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: computes the expected next selection and pulses poll_done.
  task automatic poll(input bit jv, input int ji, input string req);
    int n;
    int pick;
    n = size_of(int'(num_entries));
    if (mgmt_en && !m_mgmt) begin
      m_mgmt = 1;
      q_idx.push_back(0);
    end else begin
      m_mgmt = 0;
      if (jv && ji < n) pick = ji;
      else pick = (m_next >= n) ? 0 : m_next;
      m_next = pick + 1;
      q_idx.push_back(pick);
    end
    q_mgmt.push_back(m_mgmt);
    q_req.push_back(req);
    poll_done  = 1'b1;
    jump_valid = jv;
    jump_idx   = 13'(ji);
    @(negedge clk);
    poll_done  = 1'b0;
    jump_valid = 1'b0;
  endtask

  task automatic idle_hold(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R2 hold idx", int'(sel_idx), last_idx);
      check("R2 hold mgmt", int'(sel_mgmt), int'(last_mgmt));
    end
  endtask

  // Monitor: one accepted done per edge, result compared at the next negedge.
  always @(posedge clk) pend <= rst_n && poll_done && sel_valid;

  always @(negedge clk) begin
    if (pend) begin
      if (q_idx.size() == 0) begin
        check("R3 unexpected selection", 1, 0);
      end else begin
        int ei;
        bit em;
        string r;
        ei = q_idx.pop_front();
        em = q_mgmt.pop_front();
        r  = q_req.pop_front();
        check(r, int'(sel_idx), ei);
        check(r, int'(sel_mgmt), int'(em));
        last_idx  = int'(sel_idx);
        last_mgmt = sel_mgmt;
      end
    end
  end

  initial begin
    #(10 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; num_entries = 14'd5; mgmt_en = 1'b0;
    jump_valid = 1'b0; jump_idx = '0; poll_done = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid low in reset", int'(sel_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    poll_done = 1'b0;
    check("R1 valid after reset", int'(sel_valid), 1);
    check("R1 idx after reset", int'(sel_idx), 0);
    check("R2 done ignored while invalid", int'(sel_mgmt), 0);
    idle_hold(3);

    // R3 / R4 walk with wrap, management off (R5)
    for (int i = 0; i < 7; i++) poll(0, 0, "R3 R4 R5 sequential walk");
    idle_hold(2);
    // R8 jump, resume after jumped entry
    poll(1, 3, "R8 jump to 3");
    poll(0, 0, "R8 resume after jump");
    poll(0, 0, "R4 wrap after jump");
    // R9 out-of-range jump ignored
    poll(1, 9, "R9 out-of-range jump");
    poll(0, 0, "R9 walk unchanged");
    // R6 / R7 management interleave
    mgmt_en = 1'b1;
    poll(0, 0, "R6 management after ordinary");
    poll(0, 0, "R7 ordinary after management");
    poll(1, 0, "R9 jump when management due");
    poll(1, 0, "R8 jump from management");
    poll(0, 0, "R6 management again");
    idle_hold(2);
    poll(0, 0, "R7 resume walk");
    mgmt_en = 1'b0;
    poll(0, 0, "R5 management off");
    poll(0, 0, "R5 management off walk");
    // R4 shrink count below the walk position
    poll(1, 4, "R8 jump to 4");
    num_entries = 14'd2;
    poll(0, 0, "R4 restart after shrink");
    poll(0, 0, "R4 small table");
    poll(0, 0, "R4 small table wrap");
    num_entries = 14'd0;
    poll(0, 0, "R4 zero reads as one");
    poll(1, 1, "R9 jump beyond single entry");
    num_entries = 14'd8192;
    poll(1, 8191, "R8 jump to last entry");
    poll(0, 0, "R4 wrap at full size");
    mgmt_en = 1'b1;
    for (int i = 0; i < 6; i++) poll(0, 0, "R6 R7 interleave run");
    @(negedge clk);
    @(negedge clk);
    check("R3 all selections seen", q_idx.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule